// File: doc/BRIEF.md
# Dual-Phase Shared Memory Port

This block gives a pipelined core a single single-ported memory that serves both instruction fetch and data access. The memory is clocked from a fast clock at twice the core rate, so every core cycle holds two memory accesses. The first access fetches the instruction at the fetch address. The second access either reads or writes the word at the data address. Both results are ready before the core clock edge that closes the cycle.

Each 32-bit word is stored as two 16-bit banks that share one address. The upper bank holds bits 31..16 and the lower bank holds bits 15..0.

The fetched word goes into a holding register at the end of the data phase. It therefore stays fixed while the data phase uses the memory. The block assumes a particular clock relationship. The core clock toggles halfway between fast rising edges, and a core rising edge is followed first by a fast rising edge with the core clock high, then by one with the core clock low.

Top module: `dpm_port`

## Requirements
- R1: At every fast rising edge where rst_n is low, instr_out and rd_data become zero. Memory contents are not cleared.
- R2: The fast edge that sees clk_core high is the fetch access. The fast edge that sees clk_core low is the data access, and the phases alternate on every fast edge. A fetch of an address that is written in the same core cycle returns the old word, and the next cycle's fetch returns the new word. The memory write enable is raised only on data-phase edges.
- R3: At the core rising edge that ends a cycle, instr_out equals the word stored at that cycle's fetch_addr.
- R4: In a cycle with wr_req low, rd_data at the core rising edge that ends the cycle equals the word stored at that cycle's data_addr.
- R5: In a cycle with wr_req high, wr_data is stored at data_addr on the data-phase edge. Reads and fetches in later cycles see it. rd_data keeps its previous value across that write edge.
- R6: With wr_req low, wr_data has no effect. A later read of data_addr returns the unchanged word.
- R7: Bits 31..16 and bits 15..0 are stored and returned independently at the same address, so a word whose halves differ comes back with both halves in place.
- R8: When fetch_addr equals data_addr in a read cycle, instr_out and rd_data both return that word.
- R9: instr_out changes only on data-phase edges. Between the two fast edges of a cycle it still shows the previous cycle's instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core clock; its level on fast edges sets the phase |
| clk_fast | input | 1 | Memory clock at twice the core rate |
| rst_n | input | 1 | Synchronous active-low reset, sampled on clk_fast |
| fetch_addr | input | ADDR_W | Word address for the instruction fetch |
| data_addr | input | ADDR_W | Word address for the data read or write |
| wr_data | input | 32 | Word to store when wr_req is high |
| wr_req | input | 1 | High for a data write this cycle, low for a read |
| instr_out | output | 32 | Fetched instruction, updated on the data-phase edge |
| rd_data | output | 32 | Data read result, valid from the data-phase edge through the next core rising edge |

## Verification
A phase tracker that has slipped by one edge would route the data address into the fetch slot. The wrong word would then appear on instr_out at the end of that same core cycle. A holding register that loads on the wrong edge would show the new instruction between the two fast edges, and the mid-cycle sample catches this within one cycle. A write enable that leaks into the fetch phase, or that is raised without a request, corrupts a stored word silently. That damage only becomes visible on the next fetch or read of that address, so every address is read back after writes and after ignored write data.

// File: rtl/dpm_pkg.sv
// Shared widths and the phase encoding for the dual-phase memory port.
package dpm_pkg;
    localparam int HALF_W_DEF     = 16;
    localparam int NUM_HALVES_DEF = 2;

    // Which of the two accesses inside a core cycle is under way
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;
endpackage

// File: rtl/dpm_phase_track.sv
// Phase tracker: records the core clock level on every fast rising edge.
// The recorded level tells which access the next fast edge carries. If the
// core clock was high at the previous edge, the next edge is the data
// access; if it was low, the next edge is the fetch.
// Assumes clk_core toggles halfway between fast rising edges, so its level
// is stable whenever it is sampled.
module dpm_phase_track (
    input  logic           clk_fast,
    input  logic           clk_core,
    output dpm_pkg::phase_e phase
);
    import dpm_pkg::*;

    logic core_seen_q;

    // Sample the core clock level; left free of reset so the phase is right
    // on the first edge after reset is released
    always_ff @(posedge clk_fast) begin
        core_seen_q <= clk_core;
    end

    // Map the previous level onto the current access
    always_comb begin
        phase = core_seen_q ? PH_DATA : PH_FETCH;
    end
endmodule

// File: rtl/dpm_bank.sv
// One half-word storage bank with a registered read port on the fast clock.
// On a write edge the read register keeps its value instead of loading.
// Assumes the address and data are stable at every fast rising edge.
module dpm_bank #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk_fast,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Store the half word on a write edge
    always_ff @(posedge clk_fast) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

    // Registered read; cleared by reset and held across a write
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (!we) begin
            rdata <= store[addr];
        end
    end
endmodule

// File: rtl/dpm_steer.sv
// Access steering: picks the address for each phase and gates the write
// enable. It also captures the fetched word when the fetch phase ends.
// Assumes the bank read register holds the fetch result at the data-phase
// edge, which is the edge where it is copied here.
module dpm_steer #(
    parameter int AW = 6,
    parameter int WW = 32
) (
    input  logic            clk_fast,
    input  logic            rst_n,
    input  dpm_pkg::phase_e phase,
    input  logic [AW-1:0]   fetch_addr,
    input  logic [AW-1:0]   data_addr,
    input  logic            wr_req,
    input  logic [WW-1:0]   bank_q,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [WW-1:0]   instr_out
);
    import dpm_pkg::*;

    logic [WW-1:0] instr_q;

    // Address select and write gate for the current access
    always_comb begin
        mem_addr = (phase == PH_FETCH) ? fetch_addr : data_addr;
        mem_we   = (phase == PH_DATA) && wr_req;
    end

    // Hold the fetched word from the end of the fetch phase for a core cycle
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            instr_q <= '0;
        end else if (phase == PH_DATA) begin
            instr_q <= bank_q;
        end
    end

    assign instr_out = instr_q;
endmodule

// File: rtl/dpm_port.sv
// Dual-phase shared memory port: one single-ported memory serves an
// instruction fetch and a data access in every core cycle. The memory runs
// on a clock at twice the core rate. Storage is split into half-word banks
// that share one address.
// Assumes clk_fast is phase-locked to clk_core, with core edges falling
// midway between fast rising edges.
module dpm_port #(
    parameter int  ADDR_W     = 6,
    parameter int  HALF_W     = dpm_pkg::HALF_W_DEF,
    parameter int  NUM_HALVES = dpm_pkg::NUM_HALVES_DEF,
    localparam int WORD_W     = HALF_W * NUM_HALVES
) (
    input  logic              clk_core,
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_req,
    output logic [WORD_W-1:0] instr_out,
    output logic [WORD_W-1:0] rd_data
);
    import dpm_pkg::*;

    phase_e            phase;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [WORD_W-1:0] bank_q;

    dpm_phase_track u_phase (
        .clk_fast (clk_fast),
        .clk_core (clk_core),
        .phase    (phase)
    );

    dpm_steer #(.AW(ADDR_W), .WW(WORD_W)) u_steer (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .phase      (phase),
        .fetch_addr (fetch_addr),
        .data_addr  (data_addr),
        .wr_req     (wr_req),
        .bank_q     (bank_q),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .instr_out  (instr_out)
    );

    // One bank per half word, all on the shared address and enable
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        dpm_bank #(.AW(ADDR_W), .DW(HALF_W)) u_bank (
            .clk_fast (clk_fast),
            .rst_n    (rst_n),
            .we       (mem_we),
            .addr     (mem_addr),
            .wdata    (wr_data[h*HALF_W +: HALF_W]),
            .rdata    (bank_q[h*HALF_W +: HALF_W])
        );
    end

    assign rd_data = bank_q;
endmodule

// File: rtl/dpm_port_chk.sv
// Property checker for the dual-phase memory port, bound to every instance.
module dpm_port_chk #(
    parameter int WW = 32
) (
    input logic            clk_fast,
    input logic            clk_core,
    input logic            rst_n,
    input dpm_pkg::phase_e phase,
    input logic            mem_we,
    input logic            wr_req,
    input logic [WW-1:0]   instr_out,
    input logic [WW-1:0]   rd_data
);
    import dpm_pkg::*;

    // R1
    reset_clears_chk: assert property (@(posedge clk_fast)
        !rst_n |=> (instr_out == '0 && rd_data == '0));

    // R2
    phase_alternates_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        phase != $past(phase));

    // R2
    phase_follows_core_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_DATA) == !clk_core);

    // R2
    write_in_data_phase_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        mem_we |-> (phase == PH_DATA));

    // R6
    write_needs_request_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        mem_we |-> wr_req);

    // R5
    read_held_on_write_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_DATA && wr_req) |=> $stable(rd_data));

    // R9
    instr_held_in_fetch_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (phase == PH_FETCH) |=> $stable(instr_out));
endmodule

bind dpm_port dpm_port_chk #(.WW(WORD_W)) u_chk (
    .clk_fast  (clk_fast),
    .clk_core  (clk_core),
    .rst_n     (rst_n),
    .phase     (phase),
    .mem_we    (mem_we),
    .wr_req    (wr_req),
    .instr_out (instr_out),
    .rd_data   (rd_data)
);

// File: tb/sim_dpm_port.sv
// Bench: fills every address, overwrites a few, then sweeps all addresses
// against a model kept in the bench.
module sim_dpm_port;
    localparam int FAST_P = 10;
    localparam int CORE_P = 2 * FAST_P;
    localparam int AW     = 6;
    localparam int DEPTH  = 1 << AW;
    localparam int WW     = 32;

    logic          clk_fast = 1'b0;
    logic          clk_core = 1'b0;
    logic          rst_n    = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [AW-1:0] data_addr  = '0;
    logic [WW-1:0] wr_data    = '0;
    logic          wr_req     = 1'b0;
    logic [WW-1:0] instr_out;
    logic [WW-1:0] rd_data;

    always #(FAST_P/2) clk_fast = ~clk_fast;
    always @(negedge clk_fast) clk_core <= ~clk_core;

    dpm_port #(.ADDR_W(AW)) u0 (
        .clk_core   (clk_core),
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .fetch_addr (fetch_addr),
        .data_addr  (data_addr),
        .wr_data    (wr_data),
        .wr_req     (wr_req),
        .instr_out  (instr_out),
        .rd_data    (rd_data)
    );

    int total = 0;
    int fails = 0;

    logic [WW-1:0] model [DEPTH];
    bit            known [DEPTH];
    logic [WW-1:0] got_i, got_r, mid_i, exp_i, exp_r, last_i;
    bit            exp_i_ok, last_ok;

    function automatic logic [WW-1:0] pat(input int a, input int salt);
        logic [15:0] hi, lo;
        hi = 16'(32'hC3A0 ^ (a * 32'h0133) ^ salt);
        lo = 16'(~(32'(hi) + 32'h5A5A + a));
        return {hi, lo};
    endfunction

    task automatic chk(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One core cycle; entered and left 2 time units after a core rising edge
    task automatic cyc(input int fa, input int da, input logic [WW-1:0] wd, input bit wr);
        fetch_addr = AW'(fa);
        data_addr  = AW'(da);
        wr_data    = wd;
        wr_req     = wr;
        exp_i      = model[fa];
        exp_i_ok   = known[fa];
        exp_r      = model[da];
        @(negedge clk_core);
        #2;
        mid_i = instr_out;
        if (last_ok) chk("R9 instr held between fast edges", mid_i, last_i);
        @(posedge clk_core);
        #2;
        got_i = instr_out;
        got_r = rd_data;
        if (wr) begin
            model[da] = wd;
            known[da] = 1'b1;
        end
        last_i  = exp_i;
        last_ok = exp_i_ok;
    endtask

    initial begin
        #(CORE_P * 100000);
        fails++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int sel [4];
        sel = '{0, 63, 21, 42};
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = '0;
            known[i] = 1'b0;
        end
        last_i  = '0;
        last_ok = 1'b0;

        repeat (3) @(posedge clk_core);
        #2;
        chk("R1 instr_out in reset", instr_out, '0);
        chk("R1 rd_data in reset", rd_data, '0);
        rst_n   = 1'b1;
        last_ok = 1'b1;

        // Fill every address
        for (int a = 0; a < DEPTH; a++) begin
            cyc(a, a, pat(a, 0), 1'b1);
        end

        // R2 and R5: fetch of an address written in the same cycle
        for (int k = 0; k < 4; k++) begin
            logic [WW-1:0] old;
            old = model[sel[k]];
            cyc(sel[k], sel[k], pat(sel[k], 7), 1'b1);
            chk("R2 fetch sees word before same-cycle write", got_i, old);
            cyc(sel[k], (sel[k] + 1) % DEPTH, '0, 1'b0);
            chk("R2 next fetch sees new word", got_i, pat(sel[k], 7));
            cyc((sel[k] + 3) % DEPTH, sel[k], '0, 1'b0);
            chk("R5 written word read back", got_r, pat(sel[k], 7));
        end

        // R3, R4, R7: full sweep with distinct fetch and data addresses
        for (int a = 0; a < DEPTH; a++) begin
            int da;
            da = (a * 37 + 11) % DEPTH;
            cyc(a, da, 32'hFFFF_FFFF, 1'b0);
            chk("R3 fetched instruction", got_i, exp_i);
            chk("R4 read data", got_r, exp_r);
            if (a % 16 == 0) begin
                chk("R7 upper half", {16'h0, got_r[31:16]}, {16'h0, exp_r[31:16]});
                chk("R7 lower half", {16'h0, got_r[15:0]}, {16'h0, exp_r[15:0]});
            end
        end

        // R8 and R6: same address on both ports, write data without request
        for (int k = 0; k < 8; k++) begin
            int a;
            a = k * 9;
            cyc(a, a, ~model[a], 1'b0);
            chk("R8 same-address fetch", got_i, exp_i);
            chk("R8 same-address read", got_r, exp_r);
            cyc((a + 5) % DEPTH, a, 32'h0, 1'b0);
            chk("R6 word unchanged without request", got_r, pat(a, (a == 0 || a == 63 || a == 21 || a == 42) ? 7 : 0));
        end

        // R1: reset in mid-run clears outputs
        rst_n = 1'b0;
        @(posedge clk_core);
        #2;
        chk("R1 instr_out after mid-run reset", instr_out, '0);
        chk("R1 rd_data after mid-run reset", rd_data, '0);
        rst_n   = 1'b1;
        last_i  = '0;
        last_ok = 1'b1;
        cyc(10, 20, '0, 1'b0);
        chk("R3 fetch after reset", got_i, exp_i);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule